// File: doc/BRIEF.md
# SPI Word FIFO and Interrupt Unit

This unit is the register-facing half of an SPI master. Software reaches it through a simple bus port that completes each access in a single cycle. A serial shift engine reaches it through a word handshake. Software fills an eight-word transmit queue, and the unit hands those words to the engine while the unit is switched on. The engine hands back the words it received, and they collect in an eight-word receive queue until software drains them.

Both directions use one data offset. A write there queues a word for transmission, and a read there takes the oldest received word. Three sticky event flags are kept:

- a received-words flag, raised when the receive fill level reaches a programmable threshold;
- a transmit-drained flag;
- an overrun flag, raised when the engine delivers a word into a full receive queue.

Software reads the flags and acknowledges them at one shared offset. The interrupt line combines the received-words and overrun flags, each gated by its own enable bit.

Top module: `spiFifoIrq`

## Requirements
- R1: After reset every readable register returns 0, `txValid` and `irq` are low, and the data offset 0x24 reads 0.
- R2: A write to offset 0x24 queues a word. While control bit 0 (offset 0x00) is 1, queued words appear on `txWord` with `txValid` high and leave the queue in write order, one per cycle in which `txReady` is high. While that bit is 0, `txValid` stays low.
- R3: A word presented with `rxValid` high is queued. A read of offset 0x24 returns the oldest queued receive word and removes it. Status bit 0 (offset 0x14) reads 1 exactly while the receive queue holds a word.
- R4: Each queue holds 8 words. A write to 0x24 with 8 words waiting is discarded. A read of 0x24 with the receive queue empty returns 0 and changes nothing.
- R5: A word presented while the receive queue holds 8 words is dropped, and flag bit 0 (offset 0x1c) is set on the following cycle.
- R6: With the receive threshold (offset 0x20, bits 3:0) nonzero, flag bit 9 at 0x1c reads 1 while the receive level is at or above the threshold. Sticky flag bit 3 is set on the next cycle and stays set after the level falls. A threshold of 0 never raises either bit.
- R7: Flag bit 4 at 0x1c is set when a handoff to the engine empties the transmit queue.
- R8: Writing 1 to bit 4, 3 or 0 at offset 0x1c clears that flag. Bits written as 0 leave their flags untouched.
- R9: At offset 0x20, writing bit 12 empties the transmit queue and writing bit 4 empties the receive queue, both in one cycle. Neither bit is stored, so both read back 0. The transmit threshold (bits 11:8) and the receive threshold (bits 3:0) read back as written.
- R10: Offset 0x18 holds enable bit 3 for the received-words flag and enable bit 0 for the overrun flag. `irq` is high exactly when an enabled flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Bus write strobe |
| busRe | input | 1 | Bus read strobe (pops receive data at 0x24) |
| busAddr | input | 6 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of the access |
| txValid | output | 1 | A transmit word is offered to the engine |
| txReady | input | 1 | Engine takes the offered word |
| txWord | output | 32 | Oldest queued transmit word |
| rxValid | input | 1 | Engine delivers a received word |
| rxWord | input | 32 | Received word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, a set of invariants:

- neither queue level exceeds the queue depth;
- a word is offered only while the unit is enabled and the queue is non-empty;
- an accepted receive word raises the level by one;
- a flush empties its queue on the next cycle;
- an emptying handoff raises the transmit-drained flag;
- a delivery into a full queue raises the overrun flag;
- `irq` stays low while no flag is set.

Word ordering, the discarding of writes to a full queue, the register readback values, threshold crossing and the sticky behaviour after the level falls, selective write-one clearing, and interrupt masking can only be shown by the bench's scenarios, which compare data values against their own model.

// File: rtl/spiFifoPkg.sv
package spiFifoPkg;
  localparam int ADDR_W = 6;
  localparam int THR_W  = 4;

  // Offsets decoded by software; kept fixed.
  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_IFLG = 6'h1c;
  localparam logic [ADDR_W-1:0] OFS_FCTL = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_DATA = 6'h24;

  // Bit positions within the flag / enable / FIFO-control words
  localparam int BIT_OVR     = 0;
  localparam int BIT_RXDONE  = 3;
  localparam int BIT_TXDONE  = 4;
  localparam int BIT_RXREADY = 9;
  localparam int BIT_RXFLUSH = 4;
  localparam int BIT_TXFLUSH = 12;
  localparam int TXTHR_LSB   = 8;
  localparam int RXTHR_LSB   = 0;

  // Strobes from register control to the datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
    logic txEnable;
  } dpStrobe_t;

  typedef struct packed {
    logic txDone;
    logic rxDone;
    logic overrun;
  } evtFlags_t;
endpackage

// File: rtl/spiWordFifo.sv
module spiWordFifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] headData,
  output logic [LVL_W-1:0]  level,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              full, doPush, doPop;

  assign full     = (level == LVL_W'(DEPTH));
  assign empty    = (level == '0);
  assign doPush   = push && !full && !flush;
  assign doPop    = pop && !empty && !flush;
  assign headData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spiFifoDatapath.sv
module spiFifoDatapath
  import spiFifoPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] pushWord,
  output logic              txValid,
  input  logic              txReady,
  output logic [DATA_W-1:0] txWord,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxWord,
  output logic [DATA_W-1:0] rxHead,
  output logic              rxEmpty,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              overrunEvt,
  output logic              txEmptiedEvt
);
  logic txEmpty, txHandoff, rxFull;

  assign txValid   = strb.txEnable && !txEmpty;
  assign txHandoff = txValid && txReady;
  assign rxFull    = (rxLevel == LVL_W'(DEPTH));

  spiWordFifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .flush(strb.txFlush),
    .push(strb.txPush), .pushData(pushWord),
    .pop(txHandoff), .headData(txWord),
    .level(txLevel), .empty(txEmpty)
  );

  spiWordFifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .flush(strb.rxFlush),
    .push(rxValid), .pushData(rxWord),
    .pop(strb.rxPop), .headData(rxHead),
    .level(rxLevel), .empty(rxEmpty)
  );

  // A word arriving while full is lost, even if a pop frees a slot that cycle.
  assign overrunEvt   = rxValid && rxFull && !strb.rxFlush;
  assign txEmptiedEvt = txHandoff && (txLevel == LVL_W'(1))
                        && !strb.txPush && !strb.txFlush;
endmodule

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiFifoPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] rxHead,
  input  logic              rxEmpty,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              overrunEvt,
  input  logic              txEmptiedEvt,
  output dpStrobe_t         strb,
  output evtFlags_t         flags,
  output logic              irq
);
  logic             enReg, ieRxDone, ieOvr;
  logic [THR_W-1:0] txThr, rxThr;
  logic             rxMet;
  logic             wrCtrl, wrIen, wrIflg, wrFctl;
  evtFlags_t        clrMask, setMask;

  assign wrCtrl = busWe && (busAddr == OFS_CTRL);
  assign wrIen  = busWe && (busAddr == OFS_IEN);
  assign wrIflg = busWe && (busAddr == OFS_IFLG);
  assign wrFctl = busWe && (busAddr == OFS_FCTL);

  always_comb begin
    strb.txPush   = busWe && (busAddr == OFS_DATA);
    strb.rxPop    = busRe && (busAddr == OFS_DATA) && !rxEmpty;
    strb.txFlush  = wrFctl && busWdata[BIT_TXFLUSH];
    strb.rxFlush  = wrFctl && busWdata[BIT_RXFLUSH];
    strb.txEnable = enReg;
  end

  assign rxMet = (rxThr != '0) && (32'(rxLevel) >= 32'(rxThr));

  always_comb begin
    clrMask.txDone  = wrIflg && busWdata[BIT_TXDONE];
    clrMask.rxDone  = wrIflg && busWdata[BIT_RXDONE];
    clrMask.overrun = wrIflg && busWdata[BIT_OVR];
    setMask.txDone  = txEmptiedEvt;
    setMask.rxDone  = rxMet;
    setMask.overrun = overrunEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      ieRxDone <= 1'b0;
      ieOvr    <= 1'b0;
      txThr    <= '0;
      rxThr    <= '0;
      flags    <= '0;
    end else begin
      if (wrCtrl) enReg <= busWdata[0];
      if (wrIen) begin
        ieRxDone <= busWdata[BIT_RXDONE];
        ieOvr    <= busWdata[BIT_OVR];
      end
      if (wrFctl) begin
        txThr <= busWdata[TXTHR_LSB +: THR_W];
        rxThr <= busWdata[RXTHR_LSB +: THR_W];
      end
      // Setting beats clearing when both land in one cycle.
      flags <= (flags & ~clrMask) | setMask;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      OFS_CTRL: busRdata[0] = enReg;
      OFS_STAT: busRdata[0] = !rxEmpty;
      OFS_IEN: begin
        busRdata[BIT_RXDONE] = ieRxDone;
        busRdata[BIT_OVR]    = ieOvr;
      end
      OFS_IFLG: begin
        busRdata[BIT_RXREADY] = rxMet;
        busRdata[BIT_TXDONE]  = flags.txDone;
        busRdata[BIT_RXDONE]  = flags.rxDone;
        busRdata[BIT_OVR]     = flags.overrun;
      end
      OFS_FCTL: begin
        busRdata[TXTHR_LSB +: THR_W] = txThr;
        busRdata[RXTHR_LSB +: THR_W] = rxThr;
      end
      OFS_DATA: busRdata = rxEmpty ? '0 : rxHead;
      default:  busRdata = '0;
    endcase
  end

  assign irq = (flags.rxDone && ieRxDone) || (flags.overrun && ieOvr);
endmodule

// File: rtl/spiFifoIrq.sv
module spiFifoIrq
  import spiFifoPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [5:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              txValid,
  input  logic              txReady,
  output logic [DATA_W-1:0] txWord,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxWord,
  output logic              irq
);
  dpStrobe_t         strb;
  evtFlags_t         flags;
  logic [DATA_W-1:0] rxHead;
  logic              rxEmpty, overrunEvt, txEmptiedEvt;
  logic [LVL_W-1:0]  txLevel, rxLevel;

  spiRegCtrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxHead(rxHead), .rxEmpty(rxEmpty), .rxLevel(rxLevel),
    .overrunEvt(overrunEvt), .txEmptiedEvt(txEmptiedEvt),
    .strb(strb), .flags(flags), .irq(irq)
  );

  spiFifoDatapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pushWord(busWdata),
    .txValid(txValid), .txReady(txReady), .txWord(txWord),
    .rxValid(rxValid), .rxWord(rxWord), .rxHead(rxHead),
    .rxEmpty(rxEmpty), .txLevel(txLevel), .rxLevel(rxLevel),
    .overrunEvt(overrunEvt), .txEmptiedEvt(txEmptiedEvt)
  );
endmodule

// File: rtl/spiFifoIrqChk.sv
module spiFifoIrqChk
  import spiFifoPkg::*;
#(
  parameter int DEPTH  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             txValid,
  input logic             txReady,
  input logic             rxValid,
  input logic             irq,
  input dpStrobe_t        strb,
  input evtFlags_t        flags,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel
);
  // R2
  tx_offer_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (strb.txEnable && txLevel != '0));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (32'(txLevel) <= DEPTH) && (32'(rxLevel) <= DEPTH));

  // R3
  rx_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && 32'(rxLevel) < DEPTH && !strb.rxFlush && !strb.rxPop)
    |=> (32'(rxLevel) == 32'($past(rxLevel)) + 1));

  // R5
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && 32'(rxLevel) == DEPTH && !strb.rxFlush) |=> flags.overrun);

  // R7
  tx_drained_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txLevel == LVL_W'(1) && !strb.txPush && !strb.txFlush)
    |=> flags.txDone);

  // R9
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.txFlush |=> (txLevel == '0));

  // R9
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxFlush |=> (rxLevel == '0));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flags.rxDone && !flags.overrun) |-> !irq);
endmodule

bind spiFifoIrq spiFifoIrqChk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
  .rxValid(rxValid), .irq(irq), .strb(strb), .flags(flags),
  .txLevel(txLevel), .rxLevel(rxLevel)
);

// File: tb/spiFifoIrq_tb.sv
module spiFifoIrq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txValid, txReady = 1'b0;
  logic [31:0] txWord;
  logic        rxValid = 1'b0;
  logic [31:0] rxWord = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  spiFifoIrq u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txValid(txValid), .txReady(txReady), .txWord(txWord),
    .rxValid(rxValid), .rxWord(rxWord), .irq(irq)
  );

  typedef struct packed {
    logic        isWr;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [31:0] expv;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'h00, 32'h0,    32'h0},     // R1 control
    '{1'b0, 6'h14, 32'h0,    32'h0},     // R1 status
    '{1'b0, 6'h1c, 32'h0,    32'h0},     // R1 flags
    '{1'b0, 6'h24, 32'h0,    32'h0},     // R1 data empty
    '{1'b1, 6'h20, 32'h305,  32'h0},
    '{1'b0, 6'h20, 32'h0,    32'h305},   // R9 thresholds
    '{1'b1, 6'h20, 32'h1305, 32'h0},
    '{1'b0, 6'h20, 32'h0,    32'h305},   // R9 tx flush not stored
    '{1'b1, 6'h20, 32'h0315, 32'h0},
    '{1'b0, 6'h20, 32'h0,    32'h305},   // R9 rx flush not stored
    '{1'b1, 6'h18, 32'hFF,   32'h0},
    '{1'b0, 6'h18, 32'h0,    32'h9},     // R10 enables
    '{1'b0, 6'h00, 32'h0,    32'h0}      // R2 still disabled
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, expv);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busRe = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [5:0] a, input logic [31:0] expv);
    logic [31:0] d;
    busRead(a, d);
    check(req, d, expv);
  endtask

  task automatic sendRx(input logic [31:0] w);
    @(negedge clk);
    rxValid = 1'b1; rxWord = w;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic takeTx(input string req, input logic [31:0] expv);
    @(negedge clk);
    check({req, " valid"}, {31'b0, txValid}, 32'h1);
    check({req, " word"}, txWord, expv);
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 txValid", {31'b0, txValid}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].isWr) busWrite(VEC[i].addr, VEC[i].data);
      else readCheck((i < 4) ? "R1 table" : (i < 10) ? "R9 table" : "R10 table",
                     VEC[i].addr, VEC[i].expv);
    end

    // R2: queued while disabled, drained in order when enabled
    busWrite(6'h24, 32'hA1);
    busWrite(6'h24, 32'hB2);
    busWrite(6'h24, 32'hC3);
    @(negedge clk); #1;
    check("R2 disabled holds", {31'b0, txValid}, 32'h0);
    busWrite(6'h00, 32'h1);
    takeTx("R2 order", 32'hA1);
    takeTx("R2 order", 32'hB2);
    takeTx("R2 order", 32'hC3);
    #1 check("R2 drained", {31'b0, txValid}, 32'h0);
    readCheck("R7 drained flag", 6'h1c, 32'h10);
    busWrite(6'h1c, 32'h0);
    readCheck("R8 zero write", 6'h1c, 32'h10);
    busWrite(6'h1c, 32'h10);
    readCheck("R8 clear", 6'h1c, 32'h0);

    // R4: ninth transmit write discarded
    busWrite(6'h00, 32'h0);
    for (int k = 0; k < 9; k++) busWrite(6'h24, 32'h100 + k);
    busWrite(6'h00, 32'h1);
    for (int k = 0; k < 8; k++) takeTx("R4 tx full", 32'h100 + k);
    #1 check("R4 ninth dropped", {31'b0, txValid}, 32'h0);
    busWrite(6'h1c, 32'h10);

    // R3 / R6 / R10: receive threshold 2
    busWrite(6'h20, 32'h2);
    sendRx(32'hDEAD0001);
    readCheck("R3 status", 6'h14, 32'h1);
    readCheck("R6 below", 6'h1c, 32'h0);
    sendRx(32'hDEAD0002);
    readCheck("R6 reached", 6'h1c, 32'h208);
    #1 check("R10 rxdone irq", {31'b0, irq}, 32'h1);
    readCheck("R3 first", 6'h24, 32'hDEAD0001);
    readCheck("R6 sticky", 6'h1c, 32'h8);
    busWrite(6'h1c, 32'h8);
    readCheck("R8 rxdone clear", 6'h1c, 32'h0);
    #1 check("R10 irq low", {31'b0, irq}, 32'h0);
    readCheck("R3 second", 6'h24, 32'hDEAD0002);
    readCheck("R3 empty status", 6'h14, 32'h0);
    readCheck("R4 empty read", 6'h24, 32'h0);

    // R5: overrun with threshold 0
    busWrite(6'h20, 32'h0);
    for (int k = 0; k < 9; k++) sendRx(32'h200 + k);
    readCheck("R5 overrun flag", 6'h1c, 32'h1);
    #1 check("R10 ovr irq", {31'b0, irq}, 32'h1);
    busWrite(6'h18, 32'h0);
    #1 check("R10 masked", {31'b0, irq}, 32'h0);
    busWrite(6'h18, 32'h1);
    #1 check("R10 unmasked", {31'b0, irq}, 32'h1);
    for (int k = 0; k < 8; k++) readCheck("R5 kept words", 6'h24, 32'h200 + k);
    readCheck("R5 word dropped", 6'h14, 32'h0);
    busWrite(6'h1c, 32'h1);
    #1 check("R8 ovr clear irq", {31'b0, irq}, 32'h0);

    // R9: flushes
    sendRx(32'h55);
    sendRx(32'h66);
    busWrite(6'h20, 32'h10);
    readCheck("R9 rx flush", 6'h14, 32'h0);
    readCheck("R9 rx flush data", 6'h24, 32'h0);
    busWrite(6'h00, 32'h0);
    busWrite(6'h24, 32'h77);
    busWrite(6'h24, 32'h88);
    busWrite(6'h20, 32'h1000);
    busWrite(6'h00, 32'h1);
    @(negedge clk); #1;
    check("R9 tx flush", {31'b0, txValid}, 32'h0);

    done = 1'b1;
    finishRun();
  end
endmodule